// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the command core of a register-driven I2C master. Software writes a command word whose request bits ask for any mix of an address phase with START, a byte transmit, a byte receive (optionally the final byte of a read) and a STOP. The block runs the requested phases one at a time over a byte-level engine handshake and clears each request bit when its phase completes. It records interrupt status bits and the received byte. It also keeps a 4-bit master-state field that shows where it is in the transfer.

The master state, and not a bus-busy signal, decides two things. A START issued while the state is active is a repeated start. A STOP is normal only if the state carries the active flag. A STOP in any other state is flagged as abnormal and does not reach the bus.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `busy_o`, `eng_req_o`, `intr_o` and `cmd_o` are all 0.
- R2: A write accepted while `busy_o` is low clears `intr_o` and loads `cmd_o` with the request bits in the next cycle. `busy_o` is high from then on. A write while `busy_o` is high is ignored and changes neither the phases run nor the results.
- R3: Command bits are: bit0 START, bit1 transmit, bit2 receive, bit3 receive-last, bit4 STOP. The phases run in the order START, transmit, receive, STOP. Each phase is one engine operation, held on `eng_op_o` (0 start, 1 send, 2 receive, 3 stop) while `eng_req_o` is high, and it completes on `eng_done_i`.
- R4: START sets the state to 10 (repeated start) if state bit 3 is set, and to 9 (start) otherwise. The address byte on `eng_byte_o` is the buffer latched at the write: bits 7:1 are the address and bit 0 is the direction.
- R5: An acknowledged address moves the state to 8 (active). An unacknowledged address sets `intr_o` bit1 (TX_NAK) and leaves the state at 9 or 10. Transmit and receive phases of the same command are then skipped.
- R6: During transmit the state is 12 and the latched buffer is sent. An ACK sets `intr_o` bit0 (TX_ACK). A NAK sets only bit1 (TX_NAK) and skips a later receive in the same command. Afterwards the state is 8.
- R7: During receive the state is 13 and `eng_nack_o` is high exactly when receive-last was requested. Receive and receive-last together make one receive. `rx_data_o` takes the engine byte, or 0xFF on a failed receive. Afterwards the state is 8.
- R8: If state bit 3 is clear, STOP sets `intr_o` bit3 (ABNORMAL) and issues no engine operation. Otherwise the state is 11 during the stop operation and `intr_o` bit2 (NORMAL_STOP) is set. Either way the state then returns to 0.
- R9: `busy_o` falls the cycle after the last requested phase completes, and `cmd_o` is then 0. The engine is requested only while busy.
- R10: `state_o` only ever holds 0, 8, 9, 10, 11, 12 or 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 5 | Command request bits |
| buf_i | input | 8 | Data buffer (address byte or transmit byte) |
| busy_o | output | 1 | Command in progress |
| cmd_o | output | 5 | Pending request bits |
| state_o | output | 4 | Master-state field |
| intr_o | output | 4 | Interrupt status: 0 TX_ACK, 1 TX_NAK, 2 NORMAL_STOP, 3 ABNORMAL |
| rx_data_o | output | 8 | Last received byte |
| eng_req_o | output | 1 | Byte-engine operation request |
| eng_op_o | output | 2 | Engine operation code |
| eng_byte_o | output | 8 | Byte to send (address or data) |
| eng_nack_o | output | 1 | Answer the received byte with NACK |
| eng_done_i | input | 1 | Engine operation complete (one-cycle pulse) |
| eng_ack_i | input | 1 | Address/data was acknowledged |
| eng_ok_i | input | 1 | Receive succeeded |
| eng_byte_i | input | 8 | Received byte |

## Verification
The assertions assume that the engine pulses `eng_done_i` for a single cycle and only while `eng_req_o` is high. Under that assumption an operation code stays fixed until completion and each phase completes exactly once. The bench's engine responder holds to this. It waits a random 0 to 3 cycles after seeing a request, raises done for one cycle, and stays quiet otherwise. Command writes come only from the bench's write task, and the busy-write case is injected while a command is still running.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CMD_W  = 5;
  localparam int INTR_W = 4;

  localparam int CB_START = 0;
  localparam int CB_TX    = 1;
  localparam int CB_RX    = 2;
  localparam int CB_RXL   = 3;
  localparam int CB_STOP  = 4;

  localparam int IB_TX_ACK = 0;
  localparam int IB_TX_NAK = 1;
  localparam int IB_NSTOP  = 2;
  localparam int IB_ABN    = 3;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_ACTIVE  = 4'd8,
    ST_START   = 4'd9,
    ST_RESTART = 4'd10,
    ST_STOP    = 4'd11,
    ST_TXD     = 4'd12,
    ST_RXD     = 4'd13
  } mst_state_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [2:0] {
    PH_NONE,
    PH_START,
    PH_TX,
    PH_RX,
    PH_STOP
  } phase_e;
endpackage

// File: rtl/i2c_seq_pick.sv
module i2c_seq_pick
  import i2c_seq_pkg::*;
(
  input  logic [CMD_W-1:0] pend_i,
  output phase_e           phase_o
);
  // fixed phase priority: start, tx, rx, stop
  always_comb begin
    if (pend_i[CB_START])                    phase_o = PH_START;
    else if (pend_i[CB_TX])                  phase_o = PH_TX;
    else if (pend_i[CB_RX] || pend_i[CB_RXL]) phase_o = PH_RX;
    else if (pend_i[CB_STOP])                phase_o = PH_STOP;
    else                                     phase_o = PH_NONE;
  end
endmodule

// File: rtl/i2c_seq_intr.sv
module i2c_seq_intr #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] intr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    intr_o <= '0;
    else if (clr_i) intr_o <= '0;
    else            intr_o <= intr_o | set_i;
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0] buf_i,
  output logic              busy_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [3:0]        state_o,
  output logic [INTR_W-1:0] intr_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [DATA_W-1:0] eng_byte_o,
  output logic              eng_nack_o,
  input  logic              eng_done_i,
  input  logic              eng_ack_i,
  input  logic              eng_ok_i,
  input  logic [DATA_W-1:0] eng_byte_i
);
  localparam logic [DATA_W-1:0] RX_FAIL = {DATA_W{1'b1}};

  logic [CMD_W-1:0]  pend_q;
  logic              busy_q, wait_q, skip_q, nack_q;
  mst_state_e        st_q;
  eng_op_e           op_q;
  logic [DATA_W-1:0] buf_q, rx_q;
  phase_e            cur;
  logic [INTR_W-1:0] intr_set;
  logic              accept, issue, fin;

  assign accept = cmd_we_i && !busy_q;
  assign issue  = busy_q && !wait_q;
  assign fin    = wait_q && eng_done_i;

  i2c_seq_pick u_pick (
    .pend_i (pend_q),
    .phase_o(cur)
  );

  always_comb begin
    intr_set = '0;
    if (fin) begin
      unique case (op_q)
        OP_START: if (!eng_ack_i) intr_set[IB_TX_NAK] = 1'b1;
        OP_SEND:  intr_set[eng_ack_i ? IB_TX_ACK : IB_TX_NAK] = 1'b1;
        OP_STOP:  intr_set[IB_NSTOP] = 1'b1;
        default:  ;
      endcase
    end
    if (issue && cur == PH_STOP && !st_q[3]) intr_set[IB_ABN] = 1'b1;
  end

  i2c_seq_intr #(.W(INTR_W)) u_intr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .set_i (intr_set),
    .intr_o(intr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      skip_q <= 1'b0;
      nack_q <= 1'b0;
      st_q   <= ST_IDLE;
      op_q   <= OP_START;
      buf_q  <= '0;
      rx_q   <= '0;
    end else if (accept) begin
      pend_q <= cmd_i;
      buf_q  <= buf_i;
      busy_q <= 1'b1;
      skip_q <= 1'b0;
    end else if (fin) begin
      wait_q <= 1'b0;
      unique case (op_q)
        OP_START: begin
          pend_q[CB_START] <= 1'b0;
          if (eng_ack_i) st_q <= ST_ACTIVE;
          else           skip_q <= 1'b1;
        end
        OP_SEND: begin
          pend_q[CB_TX] <= 1'b0;
          st_q <= ST_ACTIVE;
          if (!eng_ack_i) skip_q <= 1'b1;
        end
        OP_RECV: begin
          pend_q[CB_RX]  <= 1'b0;
          pend_q[CB_RXL] <= 1'b0;
          st_q <= ST_ACTIVE;
          rx_q <= eng_ok_i ? eng_byte_i : RX_FAIL;
        end
        default: begin
          pend_q[CB_STOP] <= 1'b0;
          st_q <= ST_IDLE;
        end
      endcase
    end else if (issue) begin
      unique case (cur)
        PH_START: begin
          st_q   <= st_q[3] ? ST_RESTART : ST_START;
          op_q   <= OP_START;
          wait_q <= 1'b1;
        end
        PH_TX: begin
          if (skip_q) pend_q[CB_TX] <= 1'b0;
          else begin
            st_q   <= ST_TXD;
            op_q   <= OP_SEND;
            wait_q <= 1'b1;
          end
        end
        PH_RX: begin
          if (skip_q) begin
            pend_q[CB_RX]  <= 1'b0;
            pend_q[CB_RXL] <= 1'b0;
          end else begin
            st_q   <= ST_RXD;
            op_q   <= OP_RECV;
            nack_q <= pend_q[CB_RXL];
            wait_q <= 1'b1;
          end
        end
        PH_STOP: begin
          if (!st_q[3]) begin
            pend_q[CB_STOP] <= 1'b0;
            st_q <= ST_IDLE;
          end else begin
            st_q   <= ST_STOP;
            op_q   <= OP_STOP;
            wait_q <= 1'b1;
          end
        end
        default: busy_q <= 1'b0;
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign cmd_o      = pend_q;
  assign state_o    = st_q;
  assign rx_data_o  = rx_q;
  assign eng_req_o  = wait_q;
  assign eng_op_o   = op_q;
  assign eng_byte_o = buf_q;
  assign eng_nack_o = nack_q;

  assert_req_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |-> busy_o);
  assert_legal_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o inside {4'd0, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13});
  assert_op_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && !eng_done_i) |=> (eng_req_o && $stable(eng_op_o)));
  assert_start_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && eng_op_o == 2'd0) |-> (state_o == 4'd9 || state_o == 4'd10));
  assert_stop_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && eng_op_o == 2'd3 && eng_done_i) |=> state_o == 4'd0);
  assert_stop_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(intr_o[IB_NSTOP] && intr_o[IB_ABN]));
  assert_ack_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(intr_o[IB_TX_ACK] && intr_o[IB_TX_NAK]));
  assert_write_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !busy_o) |=> (busy_o && intr_o == '0));
endmodule

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [4:0] cmd = '0;
  logic [7:0] bufv = '0;
  logic       busy;
  logic [4:0] cmd_pend;
  logic [3:0] state;
  logic [3:0] intr;
  logic [7:0] rx_data;
  logic       eng_req;
  logic [1:0] eng_op;
  logic [7:0] eng_byte;
  logic       eng_nack;
  logic       eng_done = 1'b0;
  logic       eng_ack = 1'b0;
  logic       eng_ok = 1'b0;
  logic [7:0] eng_rbyte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd), .buf_i(bufv),
    .busy_o(busy), .cmd_o(cmd_pend), .state_o(state), .intr_o(intr),
    .rx_data_o(rx_data), .eng_req_o(eng_req), .eng_op_o(eng_op),
    .eng_byte_o(eng_byte), .eng_nack_o(eng_nack), .eng_done_i(eng_done),
    .eng_ack_i(eng_ack), .eng_ok_i(eng_ok), .eng_byte_i(eng_rbyte)
  );

  int checks = 0;
  int errors = 0;

  // engine plan for the current command
  bit       p_addr_ack, p_tx_ack, p_rx_ok;
  bit [7:0] p_rx_byte;

  // observed engine operations
  int log_n;
  int log_op[8];
  int log_byte[8];
  int log_nack[8];
  int log_st[8];

  // expected results
  int       exp_n;
  int       exp_op[8];
  int       exp_byte[8];
  int       exp_nack[8];
  int       exp_st[8];
  bit [3:0] exp_intr;
  bit [3:0] mdl_st = 4'd0;
  bit [7:0] mdl_rx = 8'd0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // engine responder
  initial begin
    int lat;
    lat = 0;
    log_n = 0;
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 1'b0;
      else if (eng_req) begin
        if (lat == 0) begin
          if (log_n < 8) begin
            log_op[log_n]   = int'(eng_op);
            log_byte[log_n] = int'(eng_byte);
            log_nack[log_n] = int'(eng_nack);
            log_st[log_n]   = int'(state);
          end
          log_n++;
          eng_ack   = (eng_op == 2'd0) ? p_addr_ack : (eng_op == 2'd1) ? p_tx_ack : 1'b1;
          eng_ok    = p_rx_ok;
          eng_rbyte = p_rx_byte;
          eng_done  = 1'b1;
          lat = $urandom % 4;
        end else lat--;
      end
    end
  end

  function automatic void push(input int op, input int b, input int nk, input int st);
    exp_op[exp_n] = op; exp_byte[exp_n] = b; exp_nack[exp_n] = nk; exp_st[exp_n] = st;
    exp_n++;
  endfunction

  function automatic void model(input bit [4:0] c, input bit [7:0] b);
    bit skip;
    bit [3:0] st;
    exp_n = 0; exp_intr = '0; skip = 0; st = mdl_st;
    if (c[0]) begin
      st = st[3] ? 4'd10 : 4'd9;
      push(0, b, 0, st);
      if (p_addr_ack) st = 4'd8;
      else begin exp_intr[1] = 1; skip = 1; end
    end
    if (c[1] && !skip) begin
      push(1, b, 0, 12);
      if (p_tx_ack) exp_intr[0] = 1;
      else begin exp_intr[1] = 1; skip = 1; end
      st = 4'd8;
    end
    if ((c[2] || c[3]) && !skip) begin
      push(2, b, c[3], 13);
      mdl_rx = p_rx_ok ? p_rx_byte : 8'hFF;
      st = 4'd8;
    end
    if (c[4]) begin
      if (!st[3]) exp_intr[3] = 1;
      else begin push(3, b, 0, 11); exp_intr[2] = 1; end
      st = 4'd0;
    end
    mdl_st = st;
  endfunction

  task automatic run_cmd(input bit [4:0] c, input bit [7:0] b, input bit poke);
    int waitc;
    @(negedge clk);
    while (busy) @(negedge clk);
    model(c, b);
    log_n = 0;
    cmd_we = 1'b1; cmd = c; bufv = b;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(busy == 1'b1, "R2 busy after write", int'(busy), 1);
    chk(intr == 4'd0, "R2 intr cleared", int'(intr), 0);
    chk(cmd_pend == c, "R2 cmd loaded", int'(cmd_pend), int'(c));
    if (poke) begin
      cmd_we = 1'b1; cmd = ~c; bufv = ~b;
      @(negedge clk);
      cmd_we = 1'b0;
    end
    waitc = 0;
    while (busy && waitc < 200) begin @(negedge clk); waitc++; end
    chk(!busy, "R9 busy falls", int'(busy), 0);
    chk(cmd_pend == 5'd0, "R9 cmd drained", int'(cmd_pend), 0);
    chk(log_n == exp_n, "R3 operation count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_op[i] == exp_op[i], "R3 phase order", log_op[i], exp_op[i]);
      chk(log_st[i] == exp_st[i], "R4 R6 R7 R8 state during phase", log_st[i], exp_st[i]);
      if (exp_op[i] != 2) chk(log_byte[i] == exp_byte[i], "R4 R6 sent byte", log_byte[i], exp_byte[i]);
      else chk(log_nack[i] == exp_nack[i], "R7 nack on last", log_nack[i], exp_nack[i]);
    end
    chk(intr == exp_intr, "R5 R6 R8 intr status", int'(intr), int'(exp_intr));
    chk(state == mdl_st, "R8 final state", int'(state), int'(mdl_st));
    chk(rx_data == mdl_rx, "R7 rx data", int'(rx_data), int'(mdl_rx));
    chk(state inside {4'd0, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13}, "R10 legal state",
        int'(state), 0);
  endtask

  task automatic plan(input bit a, input bit t, input bit o, input bit [7:0] rb);
    p_addr_ack = a; p_tx_ack = t; p_rx_ok = o; p_rx_byte = rb;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    plan(1, 1, 1, 8'h00);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state == 4'd0, "R1 state", int'(state), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(intr == 4'd0, "R1 intr", int'(intr), 0);
    chk(eng_req == 1'b0, "R1 req", int'(eng_req), 0);
    chk(cmd_pend == 5'd0, "R1 cmd", int'(cmd_pend), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 stop from idle: abnormal, no bus op
    run_cmd(5'b10000, 8'hA0, 0);
    // R4 fresh start + R6 tx ack + stop
    plan(1, 1, 1, 8'h00);
    run_cmd(5'b10011, 8'hA4, 0);
    // R4 start leaves active, then repeated start with rx last and stop
    run_cmd(5'b00001, 8'h51, 0);
    plan(1, 1, 1, 8'h3C);
    run_cmd(5'b11001, 8'h51, 0);
    // R5 address nak skips tx and rx, stop still normal
    plan(0, 1, 1, 8'h77);
    run_cmd(5'b10111, 8'h22, 0);
    // R6 tx nak skips rx
    plan(1, 0, 1, 8'h99);
    run_cmd(5'b00111, 8'h30, 0);
    // R7 failed receive yields FF, rx + rx_last one receive
    plan(1, 1, 0, 8'h12);
    run_cmd(5'b01100, 8'h00, 0);
    run_cmd(5'b10000, 8'h00, 0);
    // empty command
    run_cmd(5'b00000, 8'h00, 0);
    // R2 write while busy ignored
    plan(1, 1, 1, 8'h5A);
    run_cmd(5'b10111, 8'hC3, 1);

    for (int n = 0; n < 300; n++) begin
      plan(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 5) != 0, 8'($urandom));
      run_cmd(5'($urandom), 8'($urandom), ($urandom % 8) == 0);
    end

    summary();
    $finish;
  end
endmodule